// File: doc/BRIEF.md
# Software Reset Merge Controller

This block produces the active-low global reset of a chip from two causes: an asynchronous power-on reset input and a one-bit software reset request held in a writable register. The global reset clears the request bit that caused it. That clear always passes through a clocked flop, so the loop from the request to the global reset and back to the request cannot close combinationally and cannot glitch.

The request reaches the reset sequencer through a conditioning stage, and a build parameter picks one of two variants. In the registered variant the request bit is sampled by one more flop, so a software reset takes effect only while the clock runs. In the stretched variant the request bit asynchronously loads a down-counter that holds the conditioned source active. Reset then asserts with no clock edge, and the release is delayed by a set number of cycles after the bit falls. The raw request bit drives only the asynchronous load of that counter. It never reaches a D input or a clock pin.

The release of the global reset is always timed by the sequencer: a two-flop synchronizer followed by a minimum low-time counter. A sticky cause flag records that a software reset took place. It is captured only from the conditioned source and is cleared only by power-on reset or by an explicit clear strobe.

Top module: `swrst_merge`

## Requirements
- R1: While `por_n` is low, `glob_rst_n` is low with no clock edge needed, and `req_bit` and `cause_flag` are 0.
- R2: If `por_n` rises between clock edges and no software request is pending, `glob_rst_n` goes high at the (MIN_RST+1)-th rising edge after the rise and stays low before that edge.
- R3: A rising edge E0 with `req_we`=1 and `glob_rst_n` high loads `req_wdata` into `req_bit`. Writing 0 starts no reset: `glob_rst_n` stays high.
- R4: `req_bit` is cleared at the first rising edge that samples `glob_rst_n` low. Writes that a rising edge samples while `glob_rst_n` is low are ignored, and `req_bit` reads 0.
- R5: Registered variant (MODE=SRC_REGISTERED, encoding 0): after a request set at E0, `glob_rst_n` first reads low after E0+1, `req_bit` reads 0 after E0+2, and `glob_rst_n` rises at E0+MIN_RST+4.
- R6: Stretched variant (MODE=SRC_STRETCHED, encoding 1): `glob_rst_n` goes low right after E0 without another edge, `req_bit` reads 0 after E0+1, and the release is held STRETCH cycles after the bit falls, so `glob_rst_n` rises at E0+STRETCH+MIN_RST+2.
- R7: `cause_flag` is set from the conditioned source: it reads 1 after E0+2 in the registered variant and after E0+1 in the stretched variant. It stays 1 through the software reset and afterwards. When set and clear happen in the same cycle, set wins.
- R8: A rising edge with `cause_clr`=1 and no active source clears `cause_flag`.
- R9: `glob_rst_n` rises only at a clock edge, and only after the conditioned source and `por_n` have both been inactive for at least the two preceding edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| req_we | input | 1 | Write strobe for the software request bit |
| req_wdata | input | 1 | Value written to the request bit |
| cause_clr | input | 1 | Clears the sticky cause flag (write-1-to-clear) |
| glob_rst_n | output | 1 | Global reset, active low |
| req_bit | output | 1 | Readback of the software request bit |
| cause_flag | output | 1 | Sticky flag: a software reset has occurred |

## Verification
Both variants are built side by side and fed the same stimulus. Their assertion and release cycles, measured against a single write edge, tell apart the clocked path from the asynchronous path and check the exact stretch and minimum-low counts. Random sequences mix request writes of 1 and 0, writes injected during an active reset, cause clears and power-on pulses. These show that a zero write starts nothing, that writes during reset are dropped, that the flag stays set across a software reset but not across power-on, and that power-on release timing does not depend on the variant.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic {
        SRC_REGISTERED = 1'b0,
        SRC_STRETCHED  = 1'b1
    } src_mode_e;
endpackage

// File: rtl/rstc_req_bit.sv
module rstc_req_bit (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n_i,
    input  logic we_i,
    input  logic wdata_i,
    output logic req_o
);
    typedef struct packed {
        logic req;
    } req_st_t;

    req_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!rst_n_i) begin
            nxt_d.req = 1'b0;
        end else if (we_i) begin
            nxt_d.req = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_o = cur_q.req;

    // R4
    req_self_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n_i |=> !req_o);

    // R3
    req_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n_i && we_i) |=> (req_o == $past(wdata_i)));
endmodule

// File: rtl/rstc_src_cond.sv
module rstc_src_cond #(
    parameter rstc_pkg::src_mode_e MODE = rstc_pkg::SRC_REGISTERED,
    parameter int STRETCH = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_i,
    output logic src_o
);
    localparam int CW = $clog2(STRETCH + 1);

    generate
        if (MODE == rstc_pkg::SRC_REGISTERED) begin : g_reg
            typedef struct packed {
                logic smp;
            } smp_st_t;

            smp_st_t cur_q, nxt_d;

            always_comb begin
                nxt_d     = cur_q;
                nxt_d.smp = req_i;
            end

            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    cur_q <= '0;
                end else begin
                    cur_q <= nxt_d;
                end
            end

            assign src_o = cur_q.smp;

            // R5
            src_follows_req_chk: assert property (@(posedge clk) disable iff (!por_n)
                src_o |-> $past(req_i));
        end else begin : g_str
            typedef struct packed {
                logic [CW-1:0] cnt;
            } hold_st_t;

            hold_st_t cur_q, nxt_d;

            always_comb begin
                nxt_d = cur_q;
                if (cur_q.cnt != '0) begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end

            // raw request touches only the asynchronous load of this counter
            always_ff @(posedge clk or negedge por_n or posedge req_i) begin
                if (!por_n) begin
                    cur_q <= '0;
                end else if (req_i) begin
                    cur_q.cnt <= CW'(STRETCH);
                end else begin
                    cur_q <= nxt_d;
                end
            end

            assign src_o = (cur_q.cnt != '0);

            // R6
            src_hold_after_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
                $fell(req_i) |-> src_o);

            // R6
            src_active_with_req_chk: assert property (@(posedge clk) disable iff (!por_n)
                req_i |-> src_o);
        end
    endgenerate
endmodule

// File: rtl/rstc_rel_seq.sv
module rstc_rel_seq #(
    parameter int MIN_RST = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic src_i,
    output logic rst_n_o
);
    localparam int MW = $clog2(MIN_RST + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [MW-1:0] cnt;
        logic          rst;
    } seq_st_t;

    seq_st_t cur_q, nxt_d;
    logic    arst_n;

    assign arst_n = por_n & ~src_i;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sync = {cur_q.sync[0], 1'b1};
        if (cur_q.cnt != MW'(MIN_RST)) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        nxt_d.rst = cur_q.sync[1] && (cur_q.cnt == MW'(MIN_RST));
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rst_n_o = cur_q.rst;

    // R9
    release_after_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> ($past(arst_n) && $past(arst_n, 2)));

    // R5
    src_holds_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        src_i |-> !rst_n_o);
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause (
    input  logic clk,
    input  logic por_n,
    input  logic src_i,
    input  logic clr_i,
    output logic cause_o
);
    typedef struct packed {
        logic flag;
    } cause_st_t;

    cause_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_i) begin
            nxt_d.flag = 1'b0;
        end
        if (src_i) begin
            nxt_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cause_o = cur_q.flag;

    // R7
    cause_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        src_i |=> cause_o);

    // R7
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cause_o && !clr_i) |=> cause_o);

    // R8
    cause_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i && !src_i) |=> !cause_o);
endmodule

// File: rtl/swrst_merge.sv
module swrst_merge #(
    parameter rstc_pkg::src_mode_e MODE = rstc_pkg::SRC_REGISTERED,
    parameter int STRETCH = 4,
    parameter int MIN_RST = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_we,
    input  logic req_wdata,
    input  logic cause_clr,
    output logic glob_rst_n,
    output logic req_bit,
    output logic cause_flag
);
    logic src;

    rstc_req_bit u_req (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n_i (glob_rst_n),
        .we_i    (req_we),
        .wdata_i (req_wdata),
        .req_o   (req_bit)
    );

    rstc_src_cond #(
        .MODE    (MODE),
        .STRETCH (STRETCH)
    ) u_cond (
        .clk   (clk),
        .por_n (por_n),
        .req_i (req_bit),
        .src_o (src)
    );

    rstc_rel_seq #(
        .MIN_RST (MIN_RST)
    ) u_seq (
        .clk     (clk),
        .por_n   (por_n),
        .src_i   (src),
        .rst_n_o (glob_rst_n)
    );

    rstc_cause u_cause (
        .clk     (clk),
        .por_n   (por_n),
        .src_i   (src),
        .clr_i   (cause_clr),
        .cause_o (cause_flag)
    );
endmodule

// File: tb/swrst_merge_tb.sv
`timescale 1ns/1ps
module swrst_merge_tb;
    localparam int STR  = 4;
    localparam int MINR = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic por_n, req_we, req_wdata, cause_clr;
    logic rst_r, req_r, cause_r;
    logic rst_s, req_s, cause_s;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic exp_cause = 1'b0;

    swrst_merge #(.MODE(rstc_pkg::SRC_REGISTERED), .STRETCH(STR), .MIN_RST(MINR)) u_dut (
        .clk(clk), .por_n(por_n), .req_we(req_we), .req_wdata(req_wdata),
        .cause_clr(cause_clr), .glob_rst_n(rst_r), .req_bit(req_r), .cause_flag(cause_r));

    swrst_merge #(.MODE(rstc_pkg::SRC_STRETCHED), .STRETCH(STR), .MIN_RST(MINR)) u_dut_s (
        .clk(clk), .por_n(por_n), .req_we(req_we), .req_wdata(req_wdata),
        .cause_clr(cause_clr), .glob_rst_n(rst_s), .req_bit(req_s), .cause_flag(cause_s));

    function automatic int exp_first_low(bit str);
        return str ? 0 : 1;
    endfunction
    function automatic int exp_rise(bit str);
        return str ? (STR + MINR + 2) : (MINR + 4);
    endfunction
    function automatic int exp_req_clr(bit str);
        return str ? 1 : 2;
    endfunction
    function automatic int exp_cause_idx(bit str);
        return str ? 1 : 2;
    endfunction

    task automatic chk_bit(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_sw_reset(bit inject);
        int fl_r = -1, fl_s = -1, rs_r = -1, rs_s = -1;
        @(negedge clk);
        req_we = 1'b1; req_wdata = 1'b1;
        @(negedge clk);
        req_we = 1'b0;
        for (int i = 0; i <= 30; i++) begin
            if (i > 0) @(negedge clk);
            if (!rst_r && fl_r < 0) fl_r = i;
            if (!rst_s && fl_s < 0) fl_s = i;
            if (rst_r && fl_r >= 0 && rs_r < 0) rs_r = i;
            if (rst_s && fl_s >= 0 && rs_s < 0) rs_s = i;
            if (i == 0) begin
                chk_bit("R3 req set reg", req_r, 1'b1);
                chk_bit("R3 req set str", req_s, 1'b1);
            end
            if (i == exp_req_clr(0)) chk_bit("R4 R5 req cleared reg", req_r, 1'b0);
            if (i == exp_req_clr(1)) chk_bit("R4 R6 req cleared str", req_s, 1'b0);
            if (i == exp_cause_idx(0)) chk_bit("R7 cause set reg", cause_r, 1'b1);
            if (i == exp_cause_idx(1)) chk_bit("R7 cause set str", cause_s, 1'b1);
            if (inject && i == 5) begin req_we = 1'b1; req_wdata = 1'b1; end
            if (i == 6) begin
                req_we = 1'b0;
                if (inject) begin
                    chk_bit("R4 write in reset ignored reg", req_r, 1'b0);
                    chk_bit("R4 write in reset ignored str", req_s, 1'b0);
                end
            end
        end
        chk_int("R5 first low reg", fl_r, exp_first_low(0));
        chk_int("R6 first low str", fl_s, exp_first_low(1));
        chk_int("R5 R9 rise reg", rs_r, exp_rise(0));
        chk_int("R6 R9 rise str", rs_s, exp_rise(1));
        exp_cause = 1'b1;
        chk_bit("R7 cause sticky after reset reg", cause_r, 1'b1);
        chk_bit("R7 cause sticky after reset str", cause_s, 1'b1);
    endtask

    task automatic write_zero();
        logic seen_low = 1'b0;
        logic seen_req = 1'b0;
        @(negedge clk);
        req_we = 1'b1; req_wdata = 1'b0;
        @(negedge clk);
        req_we = 1'b0;
        for (int i = 0; i < 15; i++) begin
            if (!rst_r || !rst_s) seen_low = 1'b1;
            if (req_r || req_s) seen_req = 1'b1;
            @(negedge clk);
        end
        chk_bit("R3 zero write no reset", seen_low, 1'b0);
        chk_bit("R3 zero write req stays 0", seen_req, 1'b0);
        chk_bit("R7 cause unchanged reg", cause_r, exp_cause);
        chk_bit("R7 cause unchanged str", cause_s, exp_cause);
    endtask

    task automatic clr_cause();
        @(negedge clk);
        cause_clr = 1'b1;
        @(negedge clk);
        cause_clr = 1'b0;
        exp_cause = 1'b0;
        chk_bit("R8 cause cleared reg", cause_r, 1'b0);
        chk_bit("R8 cause cleared str", cause_s, 1'b0);
        chk_bit("R8 no reset from clear", rst_r & rst_s, 1'b1);
    endtask

    task automatic por_pulse();
        int rr = -1, rs = -1;
        @(negedge clk);
        #0.5 por_n = 1'b0;
        #0.5;
        chk_bit("R1 async rst reg", rst_r, 1'b0);
        chk_bit("R1 async rst str", rst_s, 1'b0);
        chk_bit("R1 req clear", req_r | req_s, 1'b0);
        chk_bit("R1 cause clear", cause_r | cause_s, 1'b0);
        exp_cause = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            if (rst_r && rr < 0) rr = i;
            if (rst_s && rs < 0) rs = i;
        end
        chk_int("R2 R9 por release reg", rr, MINR + 1);
        chk_int("R2 R9 por release str", rs, MINR + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired R1 act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int sel;
        void'($urandom(32'd20131016));
        por_n = 1'b0; req_we = 1'b0; req_wdata = 1'b0; cause_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk_bit("R1 reset state rst", rst_r | rst_s, 1'b0);
        chk_bit("R1 reset state req", req_r | req_s, 1'b0);
        chk_bit("R1 reset state cause", cause_r | cause_s, 1'b0);
        por_pulse();
        run_sw_reset(1'b0);
        write_zero();
        run_sw_reset(1'b1);
        clr_cause();
        write_zero();
        for (int k = 0; k < 40; k++) begin
            repeat ($urandom_range(1, 4)) @(negedge clk);
            sel = $urandom_range(0, 9);
            if (sel <= 3)      run_sw_reset(1'($urandom_range(0, 1)));
            else if (sel <= 5) write_zero();
            else if (sel <= 7) clr_cause();
            else if (sel == 8) por_pulse();
            else begin
                chk_bit("R3 idle rst high", rst_r & rst_s, 1'b1);
                chk_bit("R7 idle cause reg", cause_r, exp_cause);
            end
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule